// File: doc/BRIEF.md
# SPI Bridge Response Packetizer

This block builds the device-to-host bulk packets of a USB-to-SPI bridge. It emits each packet as a byte stream under ready/valid flow control, and a last-byte flag marks the final byte of every packet. On a configuration request it emits a short packet. That packet reports the bridge's transfer limits and whether full duplex is supported.

For an SPI transfer, the host first announces the transfer with a start pulse. Later the SPI side delivers the result: a status code and the number of bytes read. The block then walks an external read buffer through a combinational read port and cuts the read data into packets. The first is a response-start packet, which carries the status and the first read bytes. Continue packets follow, each tagged with the offset of its first byte.

A restart request replays the stored response from offset zero. The host uses it to recover a lost packet without running the SPI transfer again. The block does not fill the read buffer, drive the SPI bus or parse host packets.

Top module: `spi_rsp_packetizer`

## Requirements
- R1: Out of reset no packet is offered (`outValid` low) and no response is stored.
- R2: A configuration request accepted while idle yields an 8-byte packet with four little-endian 16-bit fields: identifier 1, maximum write count, maximum read count, and a feature bitmap whose bit 0 is the full-duplex parameter and whose other bits are zero.
- R3: After a successful transfer (status 0), the first packet holds identifier 5 as a 16-bit little-endian value, then the status, then the read bytes from buffer address 0 onward. It carries min(length, 60) bytes, so the packet is 4 to 64 bytes long.
- R4: Each later packet holds identifier 6, then a 16-bit little-endian data index equal to the number of read bytes already sent, then up to 60 read bytes taken from that address onward.
- R5: With a non-zero status, the first packet is exactly 4 bytes (identifier 5 and the status) and no continue packet follows.
- R6: `outLast` is high on the final byte of each packet and on no other byte. A new packet starts only after the previous one has fully drained.
- R7: While `outValid` is high and `outReady` is low, `outData`, `outValid` and `outLast` hold their values.
- R8: Once the final packet of a response or configuration reply has drained, the block returns to idle and offers nothing more.
- R9: A restart request in idle with a stored response replays the whole response from offset 0.
- R10: A restart request while a response is in progress lets the current packet finish, then restarts with the first packet at offset 0.
- R11: A restart request is ignored when no response is stored. A transfer result is ignored unless a transfer was announced. A configuration request is ignored while a response is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgReq | input | 1 | Pulse: send the configuration reply |
| xferStart | input | 1 | Pulse: an SPI transfer has been announced |
| xferDone | input | 1 | Pulse: SPI transfer finished, status and length valid |
| xferStatus | input | 16 | Transfer status code, 0 means success |
| xferLen | input | LEN_W | Number of bytes read into the buffer |
| restartReq | input | 1 | Pulse: replay the response from offset 0 |
| rdAddr | output | LEN_W | Read buffer address |
| rdData | input | 8 | Read buffer byte at `rdAddr`, same cycle |
| outData | output | 8 | Packet byte |
| outValid | output | 1 | Packet byte offered |
| outReady | input | 1 | Sink accepts the byte |
| outLast | output | 1 | Final byte of the packet |

## Verification
The bench targets the packet boundaries. These include a 100-byte read split 64/44, a 298-byte read whose last continue packet is short, and a zero-length read that yields a bare 4-byte start packet. A design that sized chunks wrongly, or used an offset off by four, would emit wrong lengths or shifted data and a wrong data index. A restart is issued while the first packet is stalled, together with a configuration request. A design that aborted mid-packet, forgot to rewind the offset, or obeyed the configuration request would emit a truncated packet, a continue packet where the start should repeat, or a stray 8-byte reply. Error-status, no-stored-response restart and unannounced-result cases check that nothing extra appears. Backpressure runs check that bytes are neither lost nor repeated.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_SEND_CFG,
    MODE_START_SPI,
    MODE_START_RSP,
    MODE_CONT_RSP
  } modeT;

  localparam logic [7:0] ID_CFG   = 8'd1;
  localparam logic [7:0] ID_START = 8'd5;
  localparam logic [7:0] ID_CONT  = 8'd6;

  localparam int PKT_LEN_W = 7;

  typedef struct packed {
    logic                 launch;
    logic                 isCfg;
    logic [7:0]           pktId;
    logic [15:0]          fieldA;
    logic [15:0]          fieldB;
    logic [15:0]          fieldC;
    logic [PKT_LEN_W-1:0] pktLen;
    logic [15:0]          baseAddr;
  } strobeT;

endpackage

// File: rtl/spi_rsp_ctrl.sv
module spi_rsp_ctrl
  import spi_rsp_pkg::*;
#(
  parameter int MAX_WRITE   = 298,
  parameter int MAX_READ    = 298,
  parameter bit FULL_DUPLEX = 1'b1,
  parameter int START_PAY   = 60,
  parameter int CONT_PAY    = 60,
  parameter int LEN_W       = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgReq,
  input  logic             xferStart,
  input  logic             xferDone,
  input  logic [15:0]      xferStatus,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             restartReq,
  input  logic             pktDone,
  output strobeT           strb
);

  localparam logic [15:0] START_PAY16 = 16'(START_PAY);
  localparam logic [15:0] CONT_PAY16  = 16'(CONT_PAY);
  localparam logic [15:0] FEATURES    = {15'd0, FULL_DUPLEX};

  modeT             mode;
  logic             launched;
  logic             hasRsp;
  logic             restartPend;
  logic [15:0]      rspStatus;
  logic [LEN_W-1:0] rspLen;
  logic [LEN_W-1:0] sentCnt;

  logic [15:0] remaining;
  logic [15:0] chunkStart;
  logic [15:0] chunkCont;
  logic [15:0] chunkNow;
  logic [15:0] nextSent;

  always_comb begin
    remaining  = 16'(rspLen) - 16'(sentCnt);
    if (rspStatus != 16'd0)          chunkStart = 16'd0;
    else if (remaining > START_PAY16) chunkStart = START_PAY16;
    else                              chunkStart = remaining;
    chunkCont  = (remaining > CONT_PAY16) ? CONT_PAY16 : remaining;
    chunkNow   = (mode == MODE_START_RSP) ? chunkStart : chunkCont;
    nextSent   = 16'(sentCnt) + chunkNow;
  end

  always_comb begin
    strb = '0;
    if (!launched) begin
      unique case (mode)
        MODE_SEND_CFG: begin
          strb.launch = 1'b1;
          strb.isCfg  = 1'b1;
          strb.pktId  = ID_CFG;
          strb.fieldA = 16'(MAX_WRITE);
          strb.fieldB = 16'(MAX_READ);
          strb.fieldC = FEATURES;
          strb.pktLen = PKT_LEN_W'(8);
        end
        MODE_START_RSP: begin
          strb.launch   = 1'b1;
          strb.pktId    = ID_START;
          strb.fieldA   = rspStatus;
          strb.pktLen   = PKT_LEN_W'(16'd4 + chunkStart);
          strb.baseAddr = 16'(sentCnt);
        end
        MODE_CONT_RSP: begin
          strb.launch   = 1'b1;
          strb.pktId    = ID_CONT;
          strb.fieldA   = 16'(sentCnt);
          strb.pktLen   = PKT_LEN_W'(16'd4 + chunkCont);
          strb.baseAddr = 16'(sentCnt);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode        <= MODE_IDLE;
      launched    <= 1'b0;
      hasRsp      <= 1'b0;
      restartPend <= 1'b0;
      rspStatus   <= '0;
      rspLen      <= '0;
      sentCnt     <= '0;
    end else begin
      if (strb.launch) launched <= 1'b1;
      unique case (mode)
        MODE_IDLE: begin
          if (cfgReq) begin
            mode <= MODE_SEND_CFG;
          end else if (xferStart) begin
            mode   <= MODE_START_SPI;
            hasRsp <= 1'b0;
          end else if (restartReq && hasRsp) begin
            mode    <= MODE_START_RSP;
            sentCnt <= '0;
          end
        end
        MODE_SEND_CFG: begin
          if (pktDone) begin
            launched <= 1'b0;
            mode     <= MODE_IDLE;
          end
        end
        MODE_START_SPI: begin
          if (xferDone) begin
            rspStatus <= xferStatus;
            rspLen    <= xferLen;
            hasRsp    <= 1'b1;
            sentCnt   <= '0;
            mode      <= MODE_START_RSP;
          end
        end
        MODE_START_RSP, MODE_CONT_RSP: begin
          if (restartReq) restartPend <= 1'b1;
          if (pktDone) begin
            launched <= 1'b0;
            if (restartReq || restartPend) begin
              restartPend <= 1'b0;
              sentCnt     <= '0;
              mode        <= MODE_START_RSP;
            end else begin
              sentCnt <= LEN_W'(nextSent);
              if (mode == MODE_START_RSP && rspStatus != 16'd0)
                mode <= MODE_IDLE;
              else if (nextSent == 16'(rspLen))
                mode <= MODE_IDLE;
              else
                mode <= MODE_CONT_RSP;
            end
          end
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end

  // R4
  sent_le_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt <= rspLen);

  // R11
  no_rsp_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE && !hasRsp && restartReq && !cfgReq && !xferStart)
      |=> (mode == MODE_IDLE));

  // R5
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_START_RSP && pktDone && rspStatus != 16'd0 &&
     !restartReq && !restartPend) |=> (mode == MODE_IDLE));

endmodule

// File: rtl/spi_rsp_dpath.sv
module spi_rsp_dpath
  import spi_rsp_pkg::*;
#(
  parameter int PKT_MAX = 64,
  parameter int ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic [7:0]        outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast,
  output logic              pktDone
);

  logic                 busy;
  logic                 isCfgR;
  logic [7:0]           idR;
  logic [15:0]          fieldAR;
  logic [15:0]          fieldBR;
  logic [15:0]          fieldCR;
  logic [PKT_LEN_W-1:0] lenR;
  logic [15:0]          baseR;
  logic [PKT_LEN_W-1:0] idx;

  logic [PKT_LEN_W-1:0] hdrBytes;
  logic [15:0]          addrFull;
  logic                 fire;

  always_comb begin
    hdrBytes = isCfgR ? PKT_LEN_W'(8) : PKT_LEN_W'(4);
    addrFull = baseR + 16'(idx) - 16'd4;
    rdAddr   = addrFull[ADDR_W-1:0];
    if (idx >= hdrBytes) begin
      outData = rdData;
    end else begin
      unique case (idx[2:0])
        3'd0:    outData = idR;
        3'd1:    outData = 8'd0;
        3'd2:    outData = fieldAR[7:0];
        3'd3:    outData = fieldAR[15:8];
        3'd4:    outData = fieldBR[7:0];
        3'd5:    outData = fieldBR[15:8];
        3'd6:    outData = fieldCR[7:0];
        default: outData = fieldCR[15:8];
      endcase
    end
    outValid = busy;
    outLast  = busy && (idx == lenR - PKT_LEN_W'(1));
    fire     = busy && outReady;
    pktDone  = fire && outLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isCfgR  <= 1'b0;
      idR     <= '0;
      fieldAR <= '0;
      fieldBR <= '0;
      fieldCR <= '0;
      lenR    <= '0;
      baseR   <= '0;
      idx     <= '0;
    end else if (strb.launch) begin
      busy    <= 1'b1;
      isCfgR  <= strb.isCfg;
      idR     <= strb.pktId;
      fieldAR <= strb.fieldA;
      fieldBR <= strb.fieldB;
      fieldCR <= strb.fieldC;
      lenR    <= strb.pktLen;
      baseR   <= strb.baseAddr;
      idx     <= '0;
    end else if (fire) begin
      if (outLast) busy <= 1'b0;
      else         idx  <= idx + PKT_LEN_W'(1);
    end
  end

  // R6
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.launch |-> !busy);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R6
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lenR >= PKT_LEN_W'(4) && 32'(lenR) <= PKT_MAX));

endmodule

// File: rtl/spi_rsp_packetizer.sv
module spi_rsp_packetizer
  import spi_rsp_pkg::*;
#(
  parameter int MAX_WRITE   = 298,
  parameter int MAX_READ    = 298,
  parameter bit FULL_DUPLEX = 1'b1,
  parameter int START_PAY   = 60,
  parameter int CONT_PAY    = 60,
  parameter int LEN_W       = $clog2(MAX_READ + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgReq,
  input  logic             xferStart,
  input  logic             xferDone,
  input  logic [15:0]      xferStatus,
  input  logic [LEN_W-1:0] xferLen,
  input  logic             restartReq,
  output logic [LEN_W-1:0] rdAddr,
  input  logic [7:0]       rdData,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast
);

  localparam int PKT_MAX = 4 + ((START_PAY > CONT_PAY) ? START_PAY : CONT_PAY);

  strobeT strb;
  logic   pktDone;

  spi_rsp_ctrl #(
    .MAX_WRITE  (MAX_WRITE),
    .MAX_READ   (MAX_READ),
    .FULL_DUPLEX(FULL_DUPLEX),
    .START_PAY  (START_PAY),
    .CONT_PAY   (CONT_PAY),
    .LEN_W      (LEN_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgReq    (cfgReq),
    .xferStart (xferStart),
    .xferDone  (xferDone),
    .xferStatus(xferStatus),
    .xferLen   (xferLen),
    .restartReq(restartReq),
    .pktDone   (pktDone),
    .strb      (strb)
  );

  spi_rsp_dpath #(
    .PKT_MAX(PKT_MAX),
    .ADDR_W (LEN_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .outData (outData),
    .outValid(outValid),
    .outReady(outReady),
    .outLast (outLast),
    .pktDone (pktDone)
  );

endmodule

// File: tb/spi_rsp_packetizer_tb.sv
module spi_rsp_packetizer_tb;

  localparam int LEN_W = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgReq = 1'b0;
  logic             xferStart = 1'b0;
  logic             xferDone = 1'b0;
  logic [15:0]      xferStatus = '0;
  logic [LEN_W-1:0] xferLen = '0;
  logic             restartReq = 1'b0;
  logic [LEN_W-1:0] rdAddr;
  logic [7:0]       rdData;
  logic [7:0]       outData;
  logic             outValid;
  logic             outReady = 1'b1;
  logic             outLast;

  int total = 0;
  int bad = 0;
  bit backPress = 1'b0;
  int cyc = 0;

  logic [7:0] got [0:63];
  logic [7:0] exp [0:63];
  int gotLen;
  int expLen;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] memByte(input int a);
    return 8'((a * 13 + 5) ^ (a >> 8));
  endfunction

  assign rdData = memByte(int'(rdAddr));

  spi_rsp_packetizer u_dut (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .xferStart(xferStart),
    .xferDone(xferDone), .xferStatus(xferStatus), .xferLen(xferLen),
    .restartReq(restartReq), .rdAddr(rdAddr), .rdData(rdData),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic getPkt();
    int waitCnt = 0;
    gotLen = 0;
    forever begin
      @(negedge clk);
      outReady = backPress ? ((cyc % 3) != 0) : 1'b1;
      if (outValid && outReady) begin
        if (gotLen < 64) got[gotLen] = outData;
        gotLen++;
        if (outLast) break;
      end
      waitCnt++;
      if (waitCnt > 3000) begin
        chk(1'b0, "R6 packet timeout", gotLen, expLen);
        break;
      end
    end
    outReady = 1'b1;
  endtask

  task automatic cmpPkt(input string req);
    int firstBad = -1;
    chk(gotLen == expLen, {req, " length"}, gotLen, expLen);
    for (int i = 0; i < expLen && i < gotLen; i++)
      if (firstBad < 0 && got[i] !== exp[i]) firstBad = i;
    if (firstBad >= 0)
      chk(1'b0, $sformatf("%s byte %0d", req, firstBad), int'(got[firstBad]), int'(exp[firstBad]));
    else
      chk(1'b1, req, 0, 0);
  endtask

  task automatic expStart(input logic [15:0] st, input int len);
    int n;
    exp[0] = 8'd5; exp[1] = 8'd0; exp[2] = st[7:0]; exp[3] = st[15:8];
    n = (st != 16'd0) ? 0 : ((len > 60) ? 60 : len);
    for (int i = 0; i < n; i++) exp[4 + i] = memByte(i);
    expLen = 4 + n;
  endtask

  task automatic expCont(input int base, input int len);
    int n;
    n = ((len - base) > 60) ? 60 : (len - base);
    exp[0] = 8'd6; exp[1] = 8'd0; exp[2] = 8'(base); exp[3] = 8'(base >> 8);
    for (int i = 0; i < n; i++) exp[4 + i] = memByte(base + i);
    expLen = 4 + n;
  endtask

  task automatic noMore(input string req);
    int seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (outValid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic announce(input logic [15:0] st, input int len);
    @(negedge clk); xferStart = 1'b1;
    @(negedge clk); xferStart = 1'b0;
    @(negedge clk); xferStatus = st; xferLen = LEN_W'(len); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
  endtask

  task automatic collectRsp(input int len, input string req);
    expStart(16'd0, len); getPkt(); cmpPkt({req, " R3 start"});
    for (int b = 60; b < len; b += 60) begin
      expCont(b, len); getPkt(); cmpPkt($sformatf("%s R4 cont@%0d", req, b));
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(outValid == 1'b0, "R1 reset valid", int'(outValid), 0);
  endtask

  task automatic testIdleIgnore();
    @(negedge clk); restartReq = 1'b1;
    @(negedge clk); restartReq = 1'b0;
    noMore("R11 restart without stored response");
    @(negedge clk); xferStatus = 0; xferLen = 9'd20; xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    noMore("R11 unannounced result");
  endtask

  task automatic testConfig();
    @(negedge clk); cfgReq = 1'b1;
    @(negedge clk); cfgReq = 1'b0;
    exp[0] = 8'd1; exp[1] = 8'd0; exp[2] = 8'h2A; exp[3] = 8'h01;
    exp[4] = 8'h2A; exp[5] = 8'h01; exp[6] = 8'h01; exp[7] = 8'h00;
    expLen = 8;
    getPkt(); cmpPkt("R2 config");
    noMore("R8 idle after config");
  endtask

  task automatic testRead(input int len, input bit bp, input string req);
    backPress = bp;
    announce(16'd0, len);
    collectRsp(len, req);
    backPress = 1'b0;
    noMore({req, " R8 idle after response"});
  endtask

  task automatic testError();
    announce(16'd3, 100);
    expStart(16'd3, 100); getPkt(); cmpPkt("R5 error start");
    noMore("R5 no continue after error");
  endtask

  task automatic testRestartIdle();
    testRead(100, 1'b0, "R9 original");
    @(negedge clk); restartReq = 1'b1;
    @(negedge clk); restartReq = 1'b0;
    collectRsp(100, "R9 replay");
    noMore("R9 R8 idle after replay");
  endtask

  task automatic testRestartMid();
    @(negedge clk); outReady = 1'b0;
    announce(16'd0, 200);
    repeat (5) @(negedge clk);
    chk(outValid == 1'b1, "R7 stalled start offered", int'(outValid), 1);
    restartReq = 1'b1; cfgReq = 1'b1;
    @(negedge clk); restartReq = 1'b0; cfgReq = 1'b0;
    expStart(16'd0, 200); getPkt(); cmpPkt("R10 interrupted start");
    collectRsp(200, "R10 restarted");
    noMore("R10 R11 no config reply after restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdleIgnore();
    testConfig();
    testRead(100, 1'b0, "len100");
    testRead(298, 1'b1, "R7 len298 backpressure");
    testRead(0, 1'b0, "len0");
    testRead(61, 1'b1, "len61");
    testError();
    testRestartIdle();
    testRestartMid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule